// File: doc/BRIEF.md
# Dirty Tile Tracking Unit

This block sits beside a 16 KB video memory and watches its byte writes. The memory is cut into 512 pattern tiles of 32 bytes each. Each tile is cut into eight rows of 4 bytes. For every tile the block keeps an 8-bit row mask that shows which rows have changed. It also keeps an ordered list of the tiles that have gone from clean to dirty. A tile enters that list only once: on the write that first makes its mask non-zero. A write whose data matched the byte already stored is flagged by the writer and marks nothing.

The renderer drains the list through a read port. It presents a list position and, one cycle later, gets back the tile number held there and that tile's row mask. The mask is cleared by the read. A separate one-cycle pulse sets the list length back to zero once the renderer has consumed the entries. The masks are not touched by that pulse.

Top module: `dirty_tile_tracker`

## Requirements
- R1: A marking write (wr_en high and wr_changed high) selects tile number wr_addr[13:5]. A later read of the list entry for that tile returns that number on rd_tile.
- R2: The marking write sets mask bit wr_addr[4:2] of the selected tile (bit 0 is bytes 0..3 of the tile, bit 7 is bytes 28..31). Bits set earlier stay set.
- R3: A tile is appended at position list_count, and list_count rises by one, only when the tile's mask was zero before the write. Further marks of a dirty tile leave list_count unchanged, so a tile never appears twice between drains.
- R4: A cycle with wr_en low, or with wr_changed low, changes no mask and no list entry and leaves list_count unchanged.
- R5: rd_en high with rd_idx below list_count gives rd_valid high in the next cycle. In that cycle rd_tile is the entry at rd_idx and rd_mask is that tile's mask as it was before the read. The mask becomes zero after the read, and rd_valid is low after a cycle without rd_en.
- R6: When a marking write and a read hit the same tile in the same cycle, rd_mask returns the mask from before that cycle. The mark wins: the mask afterwards holds only the new row bit, and the tile is appended again.
- R7: A clr_list pulse sets list_count to zero and leaves every mask unchanged. An append in the same cycle is stored at position 0, and list_count becomes 1.
- R8: After reset, list_count is 0, rd_valid is low, and every mask and list entry is zero.
- R9: list_count never exceeds 512. When the list is full, an append is dropped, but the row bit is still set in the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | A byte write to video memory happens in this cycle |
| wr_addr | input | 14 | Byte address of the write |
| wr_changed | input | 1 | The written data differs from the stored byte |
| rd_en | input | 1 | Read and clear one list entry |
| rd_idx | input | 9 | List position to read |
| clr_list | input | 1 | Set list_count to zero |
| rd_valid | output | 1 | rd_tile and rd_mask carry a read result |
| rd_tile | output | 9 | Tile number read from the list |
| rd_mask | output | 8 | Row mask of that tile before the read cleared it |
| list_count | output | 10 | Number of valid list entries |

## Verification
The assertions assume that the renderer only reads positions below list_count. They also assume that it pulses clr_list only after draining, which keeps list_count at or below 512 except in the deliberate full-list case. The bench keeps to this: every read targets an entry that an earlier write produced. Reset is reapplied before the full-list test, so that all 512 tiles start clean and each one is appended exactly once. Simultaneous mark-and-read is driven only for a tile already in the list.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  // Default geometry: 16 KB space, 32-byte tiles, 4-byte rows
  localparam int unsigned DTT_ADDR_W     = 14;
  localparam int unsigned DTT_TILE_SHIFT = 5;
  localparam int unsigned DTT_ROW_SHIFT  = 2;
endpackage

// File: rtl/dtt_addr_decode.sv
module dtt_addr_decode #(
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned TILE_SHIFT = 5,
  parameter int unsigned ROW_SHIFT  = 2,
  localparam int unsigned TILE_W    = ADDR_W - TILE_SHIFT,
  localparam int unsigned ROW_W     = TILE_SHIFT - ROW_SHIFT,
  localparam int unsigned ROWS      = 1 << ROW_W
) (
  input  logic              wr_en,
  input  logic              wr_changed,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              mark_vld,
  output logic [TILE_W-1:0] mark_tile,
  output logic [ROWS-1:0]   mark_row
);
  logic [ROW_W-1:0] row_sel;

  assign mark_vld  = wr_en & wr_changed;
  assign mark_tile = wr_addr[ADDR_W-1:TILE_SHIFT];
  assign row_sel   = wr_addr[TILE_SHIFT-1:ROW_SHIFT];

  // one-hot row select
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign mark_row[r] = (row_sel == ROW_W'(r));
  end
endmodule

// File: rtl/dtt_mask_bank.sv
module dtt_mask_bank #(
  parameter int unsigned TILE_W = 9,
  parameter int unsigned ROWS   = 8,
  localparam int unsigned NUM_TILES = 1 << TILE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark_vld,
  input  logic [TILE_W-1:0] mark_tile,
  input  logic [ROWS-1:0]   mark_row,
  input  logic              clr_vld,
  input  logic [TILE_W-1:0] clr_tile,
  output logic              mark_first,
  output logic [ROWS-1:0]   clr_mask
);
  logic [ROWS-1:0] mask_q [NUM_TILES];
  logic [ROWS-1:0] mask_d [NUM_TILES];
  logic [NUM_TILES-1:0] mask_en;
  logic [ROWS-1:0] mark_cur;
  logic            same_tile;

  assign mark_cur  = mask_q[mark_tile];
  assign clr_mask  = mask_q[clr_tile];
  assign same_tile = mark_vld & clr_vld & (mark_tile == clr_tile);
  // a tile is fresh when its mask is empty or is being cleared right now
  assign mark_first = (mark_cur == '0) | same_tile;

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    logic hit_mark;
    logic hit_clr;

    assign hit_mark = mark_vld & (mark_tile == TILE_W'(t));
    assign hit_clr  = clr_vld  & (clr_tile  == TILE_W'(t));

    always_comb begin
      mask_en[t] = hit_mark | hit_clr;
      if (hit_clr) begin
        mask_d[t] = hit_mark ? mark_row : '0;
      end else if (hit_mark) begin
        mask_d[t] = mask_q[t] | mark_row;
      end else begin
        mask_d[t] = mask_q[t];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[t] <= '0;
      end else if (mask_en[t]) begin
        mask_q[t] <= mask_d[t];
      end
    end
  end

  AST_MARK_ORS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_vld && !same_tile) |=>
      (mask_q[$past(mark_tile)] == ($past(mark_cur) | $past(mark_row)))); // R2

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && !same_tile) |=> (mask_q[$past(clr_tile)] == '0)); // R5

  AST_MARK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    same_tile |=> (mask_q[$past(mark_tile)] == $past(mark_row))); // R6

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    mark_vld |-> $onehot0(mark_row)); // R2
endmodule

// File: rtl/dtt_tile_list.sv
module dtt_tile_list #(
  parameter int unsigned TILE_W = 9,
  localparam int unsigned NUM_TILES = 1 << TILE_W,
  localparam int unsigned CNT_W     = TILE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              append,
  input  logic [TILE_W-1:0] append_tile,
  input  logic              clr_list,
  input  logic [TILE_W-1:0] rd_idx,
  output logic [TILE_W-1:0] rd_entry,
  output logic [CNT_W-1:0]  count
);
  logic [TILE_W-1:0] list_q [NUM_TILES];
  logic [CNT_W-1:0]  count_d;
  logic [TILE_W-1:0] wr_pos;
  logic              not_full;
  logic              store;

  assign not_full = (count < CNT_W'(NUM_TILES));
  assign store    = append & (clr_list | not_full);
  assign wr_pos   = clr_list ? '0 : count[TILE_W-1:0];
  assign rd_entry = list_q[rd_idx];

  always_comb begin
    if (clr_list) begin
      count_d = append ? CNT_W'(1) : '0;
    end else if (store) begin
      count_d = count + CNT_W'(1);
    end else begin
      count_d = count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= count_d;
    end
  end

  for (genvar e = 0; e < NUM_TILES; e++) begin : g_entry
    logic ent_en;
    assign ent_en = store & (wr_pos == TILE_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        list_q[e] <= '0;
      end else if (ent_en) begin
        list_q[e] <= append_tile;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(NUM_TILES)); // R9

  AST_APPEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (append && !clr_list && not_full) |=> (count == $past(count) + CNT_W'(1))); // R3

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!append && !clr_list) |=> $stable(count)); // R4

  AST_CLR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_list |=> (count <= CNT_W'(1))); // R7
endmodule

// File: rtl/dtt_read_port.sv
module dtt_read_port #(
  parameter int unsigned TILE_W = 9,
  parameter int unsigned ROWS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [TILE_W-1:0] tile_c,
  input  logic [ROWS-1:0]   mask_c,
  output logic              rd_valid,
  output logic [TILE_W-1:0] rd_tile,
  output logic [ROWS-1:0]   rd_mask
);
  logic [TILE_W-1:0] tile_d;
  logic [ROWS-1:0]   mask_d;

  always_comb begin
    tile_d = rd_en ? tile_c : rd_tile;
    mask_d = rd_en ? mask_c : rd_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_tile  <= '0;
      rd_mask  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_tile  <= tile_d;
      rd_mask  <= mask_d;
    end
  end

  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R5

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R5
endmodule

// File: rtl/dirty_tile_tracker.sv
module dirty_tile_tracker
  import dtt_pkg::*;
#(
  parameter int unsigned ADDR_W     = DTT_ADDR_W,
  parameter int unsigned TILE_SHIFT = DTT_TILE_SHIFT,
  parameter int unsigned ROW_SHIFT  = DTT_ROW_SHIFT,
  localparam int unsigned TILE_W    = ADDR_W - TILE_SHIFT,
  localparam int unsigned ROWS      = 1 << (TILE_SHIFT - ROW_SHIFT),
  localparam int unsigned CNT_W     = TILE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_changed,
  input  logic              rd_en,
  input  logic [TILE_W-1:0] rd_idx,
  input  logic              clr_list,
  output logic              rd_valid,
  output logic [TILE_W-1:0] rd_tile,
  output logic [ROWS-1:0]   rd_mask,
  output logic [CNT_W-1:0]  list_count
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              mark_vld;
  logic [TILE_W-1:0] mark_tile;
  logic [ROWS-1:0]   mark_row;
  logic              mark_first;
  logic [TILE_W-1:0] entry_tile;
  logic [ROWS-1:0]   entry_mask;
  logic              append;

  dtt_addr_decode #(
    .ADDR_W(ADDR_W), .TILE_SHIFT(TILE_SHIFT), .ROW_SHIFT(ROW_SHIFT)
  ) u_decode (
    .wr_en(wr_en), .wr_changed(wr_changed), .wr_addr(wr_addr),
    .mark_vld(mark_vld), .mark_tile(mark_tile), .mark_row(mark_row)
  );

  dtt_mask_bank #(.TILE_W(TILE_W), .ROWS(ROWS)) u_masks (
    .clk(clk), .rst_n(rst_sync_n),
    .mark_vld(mark_vld), .mark_tile(mark_tile), .mark_row(mark_row),
    .clr_vld(rd_en), .clr_tile(entry_tile),
    .mark_first(mark_first), .clr_mask(entry_mask)
  );

  assign append = mark_vld & mark_first;

  dtt_tile_list #(.TILE_W(TILE_W)) u_list (
    .clk(clk), .rst_n(rst_sync_n),
    .append(append), .append_tile(mark_tile), .clr_list(clr_list),
    .rd_idx(rd_idx), .rd_entry(entry_tile), .count(list_count)
  );

  dtt_read_port #(.TILE_W(TILE_W), .ROWS(ROWS)) u_rdport (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_en(rd_en), .tile_c(entry_tile), .mask_c(entry_mask),
    .rd_valid(rd_valid), .rd_tile(rd_tile), .rd_mask(rd_mask)
  );

  AST_QUIET_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(wr_en && wr_changed) && !clr_list) |=> $stable(list_count)); // R4

  AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_en |-> (CNT_W'(rd_idx) < list_count)); // R5
endmodule

// File: tb/dirty_tile_tracker_bench.sv
module dirty_tile_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_changed, rd_en, clr_list;
  logic [13:0] wr_addr;
  logic [8:0]  rd_idx;
  logic        rd_valid;
  logic [8:0]  rd_tile;
  logic [7:0]  rd_mask;
  logic [9:0]  list_count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dirty_tile_tracker u_dirty_tile_tracker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_changed(wr_changed), .rd_en(rd_en), .rd_idx(rd_idx),
    .clr_list(clr_list), .rd_valid(rd_valid), .rd_tile(rd_tile),
    .rd_mask(rd_mask), .list_count(list_count)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus, applied on the falling edge
  task automatic step(bit we, logic [13:0] a, bit chg, bit re, logic [8:0] idx, bit clr);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_changed = chg;
    rd_en = re; rd_idx = idx; clr_list = clr;
    @(negedge clk);
    wr_en = 0; wr_changed = 0; rd_en = 0; clr_list = 0;
  endtask

  task automatic wr(logic [13:0] a, bit chg);
    step(1, a, chg, 0, '0, 0);
  endtask

  task automatic rd(logic [8:0] idx, int et, int em, string req);
    step(0, '0, 0, 1, idx, 0);
    chk(req, rd_valid, 1);
    chk(req, rd_tile, et);
    chk(req, rd_mask, em);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    wr_en = 0; wr_changed = 0; rd_en = 0; clr_list = 0; wr_addr = '0; rd_idx = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R8", list_count, 0);
    chk("R8", rd_valid, 0);
  endtask

  task automatic t_basic();
    wr(14'h0024, 1);          // tile 1, row 1
    chk("R3", list_count, 1);
    wr(14'h003C, 1);          // tile 1, row 7: already listed
    chk("R3", list_count, 1);
    wr(14'h3FE0, 1);          // tile 511, row 0
    chk("R3", list_count, 2);
    rd(0, 1, 8'h82, "R1 R2 R5");
    @(negedge clk);
    chk("R5", rd_valid, 0);
    rd(0, 1, 8'h00, "R5");    // mask was cleared by the first read
    rd(1, 511, 8'h01, "R1");
    wr(14'h0024, 1);          // tile 1 clean again: appended once more
    chk("R3", list_count, 3);
    rd(2, 1, 8'h02, "R3");
  endtask

  task automatic t_unchanged();
    wr(14'h00A8, 0);          // tile 5, data unchanged
    chk("R4", list_count, 3);
    step(0, 14'h00A8, 1, 0, '0, 0);   // no strobe
    chk("R4", list_count, 3);
    wr(14'h00B0, 1);          // tile 5 row 4: still clean, so appended
    chk("R4", list_count, 4);
    rd(3, 5, 8'h10, "R4");    // only the real mark is visible
  endtask

  task automatic t_clear();
    wr(14'h0100, 1);          // tile 8 row 0
    chk("R7", list_count, 5);
    step(0, '0, 0, 0, '0, 1);
    chk("R7", list_count, 0);
    wr(14'h0104, 1);          // tile 8 still dirty: not appended
    chk("R7", list_count, 0);
    step(1, 14'h0140, 1, 0, '0, 1);   // tile 10 row 0 together with clear
    chk("R7", list_count, 1);
    rd(0, 10, 8'h01, "R7");
    wr(14'h0108, 1);          // tile 8 row 2, tile still dirty
    chk("R7", list_count, 1);
    wr(14'h0100, 1);
    chk("R7", list_count, 1);
  endtask

  task automatic t_mark_wins();
    wr(14'h00E8, 1);          // tile 7 row 2
    chk("R6", list_count, 2);
    step(1, 14'h00F4, 1, 1, 9'd1, 0); // tile 7 row 5 while reading it
    chk("R6", rd_tile, 7);
    chk("R6", rd_mask, 8'h04);
    chk("R6", list_count, 3);
    rd(2, 7, 8'h20, "R6");
  endtask

  task automatic t_full();
    do_reset();
    for (int t = 0; t < 512; t++) wr(14'(t << 5), 1);
    chk("R9", list_count, 512);
    rd(3, 3, 8'h01, "R9");
    wr(14'h0064, 1);          // tile 3 row 1: list full, append dropped
    chk("R9", list_count, 512);
    rd(3, 3, 8'h02, "R9");
    rd(511, 511, 8'h01, "R9");
  endtask

  initial begin
    rst_n = 0;
    t_reset();
    t_basic();
    t_unchanged();
    t_clear();
    t_mark_wins();
    t_full();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule